// File: doc/BRIEF.md
# Double-Buffered Emissive Pixel Drive Slice

This block holds the digital state for a row slice of self-emissive pixels. Each pixel keeps a 5-bit intensity code and two binary on/off cells. One cell is shown and the other is hidden. A global swap strobe exchanges the two cells, so two stored patterns can alternate at the clock rate without any reload.

In global mode, binary writes go to the hidden cell and appear only after a swap. In rolling mode the pixel behaves as a single bit: a write lands in the shown cell and takes effect on the next cycle. The intensity code stays fixed while binary patterns are loaded or swapped. It acts as a bias level that is presented whenever the pixel is on. A separate global pulse input is gated by each pixel's shown state to form a high-current pulse enable. That path is combinational, so nanosecond pulses pass straight through.

A shared bus carries the writes. It has a pixel index, a data word, a route bit that chooses the state cells or the intensity register, and a write strobe.

Top module: `pixel_drive_array`

## Requirements
- R1: While rst_ni is low, and directly after it rises, every on_o, level_o and burst_o bit is 0. Both state cells and the intensity code of every pixel are 0, and cell 0 is the shown cell.
- R2: With rolling_i=0, swap_i=0, wr_i=1 and route_i=0, the value data_i[0] is stored in the hidden cell of pixel sel_i. No on_o bit changes at that edge.
- R3: With rolling_i=0, each clock edge with swap_i=1 exchanges the shown and hidden cells of every pixel. Repeated swaps alternate between the two stored patterns.
- R4: A state write with rolling_i=0 and swap_i=1 in the same cycle is stored in the cell that is hidden after the swap. The pattern shown after that edge is the one that was hidden before it.
- R5: With rolling_i=1, a state write stores data_i[0] in the shown cell, so on_o[sel_i] equals that bit after the edge. swap_i has no effect while rolling_i=1.
- R6: With wr_i=1 and route_i=1, data_i[4:0] becomes the intensity code of pixel sel_i. The state cells are not changed.
- R7: level_o[5*p +: 5] equals the intensity code of pixel p while on_o[p]=1, and equals 0 while on_o[p]=0. State writes and swaps leave the code unchanged.
- R8: burst_o[p] is pulse_i AND on_o[p], combinationally. It is 0 whenever pulse_i is 0, reset included.
- R9: A write changes only pixel sel_i. A value of sel_i of N_PIX or more writes nothing.
- R10: A state write uses only data_i[0]. Bits 4:1 of data_i are ignored on that route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | IDX_W | Pixel index of the write |
| data_i | input | CODE_W | Write data: bit 0 for the state route, all bits for the intensity route |
| route_i | input | 1 | 0 = state cells, 1 = intensity register |
| wr_i | input | 1 | Write strobe |
| rolling_i | input | 1 | 1 = rolling (single-bit) mode, 0 = global double-buffered mode |
| swap_i | input | 1 | Global swap strobe, sampled at the clock edge |
| pulse_i | input | 1 | Global high-current pulse input |
| on_o | output | N_PIX | Shown on/off state per pixel |
| level_o | output | N_PIX*CODE_W | Presented intensity code per pixel |
| burst_o | output | N_PIX | High-current pulse enable per pixel |

## Verification
Writes, swaps and intensity loads are all registered once. Their effect on on_o and level_o is therefore due in the cycle after the edge that samples them. burst_o follows pulse_i with no register in between. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It then compares every pixel's three outputs 1 ns later, so each registered result is read in the cycle it is due and the pulse gate is read in the same cycle.

// File: rtl/pdrv_pkg.sv
package pdrv_pkg;
  typedef enum logic {
    ROUTE_STATE = 1'b0,
    ROUTE_LEVEL = 1'b1
  } route_e;
endpackage

// File: rtl/pdrv_decode.sv
module pdrv_decode #(
  parameter int N_PIX = 6,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] sel_i,
  input  logic             wr_i,
  output logic [N_PIX-1:0] wr_en_o
);
  for (genvar g = 0; g < N_PIX; g++) begin : g_dec
    assign wr_en_o[g] = wr_i && (sel_i == IDX_W'(g));
  end
endmodule

// File: rtl/pdrv_cell.sv
module pdrv_cell
  import pdrv_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  route_e            route_i,
  input  logic              rolling_i,
  input  logic              swap_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              pulse_i,
  output logic              on_o,
  output logic [CODE_W-1:0] level_o,
  output logic              burst_o
);
  logic [1:0]        cell_q;
  logic              shown_q;
  logic [CODE_W-1:0] code_q;
  logic              tgt;

  // rolling or same-cycle swap: write the currently shown cell
  assign tgt = (rolling_i || swap_i) ? shown_q : ~shown_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_q  <= '0;
      shown_q <= 1'b0;
      code_q  <= '0;
    end else begin
      if (wr_en_i && route_i == ROUTE_LEVEL) code_q <= data_i;
      if (wr_en_i && route_i == ROUTE_STATE) cell_q[tgt] <= data_i[0];
      if (swap_i && !rolling_i) shown_q <= ~shown_q;
    end
  end

  assign on_o    = cell_q[shown_q];
  assign level_o = on_o ? code_q : '0;
  assign burst_o = pulse_i & on_o;
endmodule

// File: rtl/pixel_drive_array.sv
module pixel_drive_array
  import pdrv_pkg::*;
#(
  parameter int N_PIX  = 6,
  parameter int CODE_W = 5,
  parameter int IDX_W  = (N_PIX > 1) ? $clog2(N_PIX) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [IDX_W-1:0]         sel_i,
  input  logic [CODE_W-1:0]        data_i,
  input  logic                     route_i,
  input  logic                     wr_i,
  input  logic                     rolling_i,
  input  logic                     swap_i,
  input  logic                     pulse_i,
  output logic [N_PIX-1:0]         on_o,
  output logic [N_PIX*CODE_W-1:0]  level_o,
  output logic [N_PIX-1:0]         burst_o
);
  logic [N_PIX-1:0] wr_en;
  route_e           route;

  assign route = route_e'(route_i);

  pdrv_decode #(.N_PIX(N_PIX), .IDX_W(IDX_W)) i_dec (
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .wr_en_o (wr_en)
  );

  for (genvar g = 0; g < N_PIX; g++) begin : g_pix
    pdrv_cell #(.CODE_W(CODE_W)) i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en[g]),
      .route_i   (route),
      .rolling_i (rolling_i),
      .swap_i    (swap_i),
      .data_i    (data_i),
      .pulse_i   (pulse_i),
      .on_o      (on_o[g]),
      .level_o   (level_o[g*CODE_W +: CODE_W]),
      .burst_o   (burst_o[g])
    );
  end
endmodule

// File: rtl/pdrv_checker.sv
module pdrv_checker #(
  parameter int N_PIX  = 6,
  parameter int CODE_W = 5,
  parameter int IDX_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [IDX_W-1:0]        sel_i,
  input logic [CODE_W-1:0]       data_i,
  input logic                    route_i,
  input logic                    wr_i,
  input logic                    rolling_i,
  input logic                    swap_i,
  input logic                    pulse_i,
  input logic [N_PIX-1:0]        on_o,
  input logic [N_PIX*CODE_W-1:0] level_o,
  input logic [N_PIX-1:0]        burst_o
);
  p_hidden_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !route_i && !rolling_i && !swap_i) |=> $stable(on_o));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && !(wr_i && !route_i)) |=> $stable(on_o));

  for (genvar g = 0; g < N_PIX; g++) begin : g_chk
    p_roll_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !route_i && rolling_i && sel_i == IDX_W'(g)) |=> on_o[g] == $past(data_i[0]));

    p_dark_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !on_o[g] |-> level_o[g*CODE_W +: CODE_W] == '0);

    p_level_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (on_o[g] && !(wr_i && route_i && sel_i == IDX_W'(g)))
        |=> (!on_o[g] || $stable(level_o[g*CODE_W +: CODE_W])));

    p_pulse_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pulse_i |-> !burst_o[g]);
  end
endmodule

bind pixel_drive_array pdrv_checker #(
  .N_PIX(N_PIX), .CODE_W(CODE_W), .IDX_W(IDX_W)
) i_chk (.*);

// File: tb/test_pixel_drive_array.sv
`timescale 1ns/1ps
module test_pixel_drive_array;
  localparam int N  = 6;
  localparam int CW = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] sel = '0;
  logic [CW-1:0] data = '0;
  logic          route = 1'b0, wr = 1'b0, roll = 1'b0, swap = 1'b0, pulse = 1'b0;
  logic [N-1:0]    on;
  logic [N*CW-1:0] level;
  logic [N-1:0]    burst;

  int checks = 0;
  int errors = 0;

  logic          m_cell [2][N];
  logic          m_shw;
  logic [CW-1:0] m_code [N];

  always #2 clk = ~clk;

  pixel_drive_array #(.N_PIX(N), .CODE_W(CW), .IDX_W(IW)) i_pixel_drive_array (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .data_i(data), .route_i(route),
    .wr_i(wr), .rolling_i(roll), .swap_i(swap), .pulse_i(pulse),
    .on_o(on), .level_o(level), .burst_o(burst)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < N; p++) begin
      logic          e_on;
      logic [CW-1:0] e_lvl;
      logic          e_bst;
      e_on  = m_cell[m_shw][p];
      e_lvl = e_on ? m_code[p] : '0;
      e_bst = pulse & e_on;
      checks++;
      if (on[p] !== e_on) begin
        errors++;
        $display("FAIL %s pix %0d on_o: got %b exp %b", tag, p, on[p], e_on);
      end
      checks++;
      if (level[p*CW +: CW] !== e_lvl) begin
        errors++;
        $display("FAIL %s pix %0d level_o: got %0d exp %0d", tag, p, level[p*CW +: CW], e_lvl);
      end
      checks++;
      if (burst[p] !== e_bst) begin
        errors++;
        $display("FAIL %s pix %0d burst_o: got %b exp %b", tag, p, burst[p], e_bst);
      end
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < N; p++) begin
      m_cell[0][p] = 1'b0;
      m_cell[1][p] = 1'b0;
      m_code[p]    = '0;
    end
    m_shw = 1'b0;
  endtask

  task automatic step(input logic [IW-1:0] s, input logic [CW-1:0] d, input logic rt,
                      input logic w, input logic rl, input logic sw, input logic pu,
                      input string tag);
    @(negedge clk);
    sel = s; data = d; route = rt; wr = w; roll = rl; swap = sw; pulse = pu;
    @(posedge clk);
    if (w && int'(s) < N) begin
      if (rt) m_code[s] = d;
      else if (rl || sw) m_cell[m_shw][s] = d[0];
      else m_cell[~m_shw][s] = d[0];
    end
    if (sw && !rl) m_shw = ~m_shw;
    #1;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    model_reset();
    pulse = 1'b1;
    #7;
    check_all("R1 in reset, R8 pulse high");
    pulse = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 after release");

    // R6: load intensities, pixels still off so level is 0 (R7)
    for (int p = 0; p < N; p++) step(IW'(p), CW'(p * 5 + 3), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 code load");
    // R5: rolling writes show next cycle; R10 upper data bits ignored
    step(3'd1, 5'b11111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 rolling on");
    step(3'd2, 5'b11110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 bit0 only");
    step(3'd0, 5'b00001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R5 swap ignored rolling");
    step(3'd0, 5'b00000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5 swap ignored, R8 pulse");
    // R2: global write to hidden cell
    for (int p = 0; p < N; p++) step(IW'(p), CW'(p[0] ? 0 : 1), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 hidden load");
    // R3: swap reveals hidden frame, repeated swaps alternate
    for (int k = 0; k < 4; k++) step(3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, k[0], "R3 alternate");
    // R4: write concurrent with swap
    step(3'd3, 5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R4 write with swap");
    step(3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 swap back");
    // R7: intensity stays under state activity; R6 reload while on
    step(3'd1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 code unchanged");
    step(3'd0, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 code reload");
    // R9: out-of-range index writes nothing
    step(3'd6, 5'd31, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 sel 6 state");
    step(3'd7, 5'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 sel 7 code");
    step(3'd7, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R9 sel 7 with swap");
    // sweep over mixed operations (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0], r[7:3], r[8], r[9] | r[10], r[11] & r[12], r[13] & r[14], r[15], "sweep");
    end
    step(3'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 pulse low end");
    summary();
  end
endmodule